// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block controls how a clock generator enters and leaves a low-power state. It receives an active-low power-down request that is not related to the core clock, and brings it safely into the clock domain. On entry, the bus and processor clock groups may finish the cycle they are in and are then parked low. Only after that are the PLL VCO and the crystal oscillator switched off. The serial configuration port is frozen while the register contents are kept. The reference and interrupt-controller clocks are gated by a separate hold that takes effect at once and does not wait for the cycle to finish.

On exit the oscillator is enabled first. The VCO follows once the first reference cycle has been seen. The clock hold stays set until a programmable number of reference cycles has passed. If the request returns during this settle window, the block drops straight back to the oscillator-off state and emits no clock pulse. The two per-group stop inputs only matter in normal running. The whole power-management function is active only when the mode strap is 0.

Top module: `pwrdn_seq`

## Requirements
- R1: `pd_req_n`, `cpu_stop_n` and `bus_stop_n` each pass through a two-flop synchronizer. A change on `pd_req_n` cannot affect any output before the third rising edge of `clk` after it.
- R2: With `mode_sel`=1, both `pd_req_n` and the stop inputs are ignored: `cpu_run`=`bus_run`=1, `clk_hold`=0 and `osc_en`=1.
- R3: With `mode_sel`=0 in normal running, `cpu_run` follows the synchronized `cpu_stop_n` and `bus_run` follows the synchronized `bus_stop_n` (1 = clock runs).
- R4: On the third edge after `pd_req_n` falls (mode 0), `ref_hold` rises while `clk_hold` is still 0. With `cycle_done`=1, `clk_hold` rises one edge later.
- R5: If `cycle_done` stays 0, `clk_hold` rises after exactly PARK_MAX cycles of waiting (default 4, i.e. on the seventh edge after the request).
- R6: `osc_en` and `vco_en` fall, and `ser_freeze` rises, one edge after `clk_hold` rises. The oscillator is never off while the clocks are free.
- R7: While `clk_hold`=1, `cpu_run` and `bus_run` are 0 whatever the stop inputs do, and the stop inputs do not change the power state.
- R8: The configuration register resets to all ones and takes `cfg_wdata` on a clock with `cfg_we`=1. While `ser_freeze`=1, writes are ignored and the value held before power-down is kept.
- R9: On the third edge after `pd_req_n` rises, `osc_en` rises with `vco_en`=0 and `clk_hold`=1. `vco_en` rises at the first `ref_tick`. `clk_hold` falls on the edge of the SETTLE_CYC-th `ref_tick` (default 8).
- R10: A renewed request during the settle window returns the block to oscillator-off (`osc_en`=0) with `clk_hold` held at 1 throughout. The settle count then restarts from zero on the next wake.
- R11: After reset: `osc_en`=`vco_en`=1, `clk_hold`=`ref_hold`=`ser_freeze`=0, and both run outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Strap: 0 enables power management, 1 disables it |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous stop for the processor clock group, active low |
| bus_stop_n | input | 1 | Asynchronous stop for the bus clock group, active low |
| cycle_done | input | 1 | Gated clocks are at a cycle boundary (low phase) |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| cfg_we | input | 1 | Serial configuration write strobe |
| cfg_wdata | input | CFG_W | Serial configuration write data |
| cfg_q | output | CFG_W | Retained configuration register |
| cpu_run | output | 1 | Processor clock group runs |
| bus_run | output | 1 | Bus clock group runs |
| ref_hold | output | 1 | Reference and interrupt-controller clocks held |
| clk_hold | output | 1 | Gated clock groups parked low |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL VCO enable |
| ser_freeze | output | 1 | Serial configuration interface frozen |

## Verification
The hardest situation to reach is a request that returns during the settle window, after part of the reference count has built up. The stimulus first completes a full park and wake, so that the reference-tick count and the frozen register are known. It then enters power-down through the timeout path and releases it. After three ticks it reasserts the request, and it checks on every cycle that no clock group runs. A final wake then needs the full tick count again and must still show the configuration value written before the first power-down.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_PARK   = 3'd1,
    ST_HELD   = 3'd2,
    ST_OSCOFF = 3'd3,
    ST_WAKE   = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async[gi]};
      end
      assign q_sync[gi] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
#(
  parameter int PARK_MAX = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_act,
  input  logic      cycle_done,
  input  logic      settle_done,
  output pd_state_e state_q
);
  localparam int PW = $clog2(PARK_MAX) + 1;

  pd_state_e     state_d;
  logic [PW-1:0] park_cnt_q, park_cnt_d;
  logic          park_to;

  assign park_to = (park_cnt_q == PW'(PARK_MAX - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (pd_act) state_d = ST_PARK;
      ST_PARK:   if (cycle_done || park_to) state_d = ST_HELD;
      ST_HELD:   state_d = ST_OSCOFF;
      ST_OSCOFF: if (!pd_act) state_d = ST_WAKE;
      ST_WAKE: begin
        if (pd_act)           state_d = ST_OSCOFF;
        else if (settle_done) state_d = ST_RUN;
      end
      default:   state_d = ST_RUN;
    endcase
  end

  always_comb begin
    if (state_q == ST_PARK) park_cnt_d = park_cnt_q + PW'(1);
    else                    park_cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      park_cnt_q <= '0;
    end else begin
      state_q    <= state_d;
      park_cnt_q <= park_cnt_d;
    end
  end

  a_r10_wake_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && pd_act) |=> (state_q == ST_OSCOFF));

  a_r5_park_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK) |-> (park_cnt_q < PW'(PARK_MAX)));
endmodule

// File: rtl/pwrdn_settle.sv
module pwrdn_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_wake,
  input  logic                            ref_tick,
  output logic                            done,
  output logic                            seen_tick,
  output logic [$clog2(SETTLE_CYC+1)-1:0] cnt_q
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en    = in_wake && ref_tick;
  assign done      = cnt_en && (cnt_q == CW'(SETTLE_CYC - 1));
  assign seen_tick = (cnt_q != '0);

  always_comb begin
    if (!in_wake)    cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CW'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwrdn_cfg.sv
module pwrdn_cfg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  logic wr_en;
  assign wr_en = we && !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '1;
    else if (wr_en) q <= wdata;
  end

  a_r8_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(q));
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int PARK_MAX   = 4,
  parameter int SETTLE_CYC = 8,
  parameter int CFG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             pd_req_n,
  input  logic             cpu_stop_n,
  input  logic             bus_stop_n,
  input  logic             cycle_done,
  input  logic             ref_tick,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             cpu_run,
  output logic             bus_run,
  output logic             ref_hold,
  output logic             clk_hold,
  output logic             osc_en,
  output logic             vco_en,
  output logic             ser_freeze
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [1:0] rst_chain_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= 2'b00;
    else        rst_chain_q <= {rst_chain_q[0], 1'b1};
  end
  assign rst_s = rst_chain_q[1];

  logic [2:0] async_in, sync_out;
  logic       pd_s, cpu_stop_s, bus_stop_s, pd_act;

  assign async_in = {pd_req_n, cpu_stop_n, bus_stop_n};

  pwrdn_sync #(.W(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_s),
    .d_async (async_in),
    .q_sync  (sync_out)
  );

  assign {pd_s, cpu_stop_s, bus_stop_s} = sync_out;
  assign pd_act = !pd_s && !mode_sel;

  pd_state_e     state;
  logic          settle_done, seen_tick;
  logic [CW-1:0] settle_cnt;

  pwrdn_fsm #(.PARK_MAX(PARK_MAX)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_s),
    .pd_act      (pd_act),
    .cycle_done  (cycle_done),
    .settle_done (settle_done),
    .state_q     (state)
  );

  pwrdn_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_wake   (state == ST_WAKE),
    .ref_tick  (ref_tick),
    .done      (settle_done),
    .seen_tick (seen_tick),
    .cnt_q     (settle_cnt)
  );

  always_comb begin
    ref_hold   = (state != ST_RUN);
    clk_hold   = (state == ST_HELD) || (state == ST_OSCOFF) || (state == ST_WAKE);
    ser_freeze = (state == ST_OSCOFF) || (state == ST_WAKE);
    osc_en     = (state != ST_OSCOFF);
    vco_en     = (state == ST_RUN) || (state == ST_PARK) || (state == ST_HELD) ||
                 ((state == ST_WAKE) && seen_tick);
    cpu_run    = !clk_hold && (mode_sel || cpu_stop_s);
    bus_run    = !clk_hold && (mode_sel || bus_stop_s);
  end

  pwrdn_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_s),
    .freeze (ser_freeze),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .q      (cfg_q)
  );

  a_r6_hold_before_osc: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(osc_en) |-> $past(clk_hold));

  a_r7_frozen_no_run: assert property (@(posedge clk) disable iff (!rst_s)
    ser_freeze |-> (!cpu_run && !bus_run));

  a_r2_mode_blocks_entry: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_sel && state == ST_RUN) |=> (state == ST_RUN));

  a_r9_release_after_count: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(clk_hold) |-> $past(settle_cnt == CW'(SETTLE_CYC - 1)));
endmodule

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
  localparam int CFG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n, mode_sel, pd_req_n, cpu_stop_n, bus_stop_n;
  logic             cycle_done, ref_tick, cfg_we;
  logic [CFG_W-1:0] cfg_wdata, cfg_q;
  logic             cpu_run, bus_run, ref_hold, clk_hold, osc_en, vco_en, ser_freeze;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  pwrdn_seq #(.PARK_MAX(4), .SETTLE_CYC(8), .CFG_W(CFG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pd_req_n(pd_req_n),
    .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n), .cycle_done(cycle_done),
    .ref_tick(ref_tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .cpu_run(cpu_run), .bus_run(bus_run), .ref_hold(ref_hold), .clk_hold(clk_hold),
    .osc_en(osc_en), .vco_en(vco_en), .ser_freeze(ser_freeze)
  );

  // row fields: pd_req_n, mode_sel, cpu_stop_n, bus_stop_n | exp cpu_run, bus_run, clk_hold
  localparam logic [6:0] VEC [9] = '{
    7'b1011_110, 7'b1001_010, 7'b1010_100, 7'b1000_000,
    7'b1100_110, 7'b0111_110, 7'b0100_110, 7'b1111_110, 7'b1011_110
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog run did not complete actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 1'b0; pd_req_n = 1'b1; cpu_stop_n = 1'b1;
    bus_stop_n = 1'b1; cycle_done = 1'b0; ref_tick = 1'b0; cfg_we = 1'b0;
    cfg_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R11 reset state
    chk("R11", "osc_en", osc_en, 1);
    chk("R11", "vco_en", vco_en, 1);
    chk("R11", "clk_hold", clk_hold, 0);
    chk("R11", "ref_hold", ref_hold, 0);
    chk("R11", "ser_freeze", ser_freeze, 0);
    chk("R11", "run", {cpu_run, bus_run}, 2'b11);
    chk("R8", "cfg reset", cfg_q, 8'hFF);

    // table walk: R2 rows have mode_sel=1, R3 rows mode_sel=0
    for (int i = 0; i < 9; i++) begin
      {pd_req_n, mode_sel, cpu_stop_n, bus_stop_n} = VEC[i][6:3];
      repeat (3) step();
      chk(VEC[i][5] ? "R2" : "R3", "cpu_run", cpu_run, VEC[i][2]);
      chk(VEC[i][5] ? "R2" : "R3", "bus_run", bus_run, VEC[i][1]);
      chk(VEC[i][5] ? "R2" : "R3", "clk_hold", clk_hold, VEC[i][0]);
      if (VEC[i][5]) chk("R2", "osc_en", osc_en, 1);
    end

    // R8 write while running
    cfg_we = 1'b1; cfg_wdata = 8'hA5;
    step();
    cfg_we = 1'b0;
    chk("R8", "cfg write", cfg_q, 8'hA5);

    // entry with cycle boundary present
    cycle_done = 1'b1; pd_req_n = 1'b0;
    step(); chk("R1", "ref_hold edge1", ref_hold, 0);
    step(); chk("R1", "ref_hold edge2", ref_hold, 0);
    step();
    chk("R4", "ref_hold edge3", ref_hold, 1);
    chk("R4", "clk_hold edge3", clk_hold, 0);
    step();
    chk("R4", "clk_hold edge4", clk_hold, 1);
    chk("R6", "osc still on", osc_en, 1);
    chk("R7", "cpu_run parked", cpu_run, 0);
    step();
    chk("R6", "osc_en off", osc_en, 0);
    chk("R6", "vco_en off", vco_en, 0);
    chk("R6", "ser_freeze", ser_freeze, 1);

    // stop inputs are don't-care while down
    cpu_stop_n = 1'b0; bus_stop_n = 1'b0;
    repeat (3) step();
    cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
    repeat (3) step();
    chk("R7", "run outputs", {cpu_run, bus_run}, 2'b00);
    chk("R7", "still off", osc_en, 0);

    // frozen write ignored
    cfg_we = 1'b1; cfg_wdata = 8'h00;
    step();
    cfg_we = 1'b0;
    chk("R8", "frozen write", cfg_q, 8'hA5);

    // wake
    cycle_done = 1'b0; pd_req_n = 1'b1;
    step(); step();
    chk("R9", "osc before edge3", osc_en, 0);
    step();
    chk("R9", "osc_en edge3", osc_en, 1);
    chk("R9", "vco_en before tick", vco_en, 0);
    chk("R9", "hold in settle", clk_hold, 1);
    ref_tick = 1'b1;
    step();
    chk("R9", "vco_en after tick", vco_en, 1);
    repeat (6) step();
    chk("R9", "hold after 7 ticks", clk_hold, 1);
    step();
    chk("R9", "hold after 8 ticks", clk_hold, 0);
    chk("R9", "cpu_run resumes", cpu_run, 1);
    ref_tick = 1'b0;
    step();

    // R5 timeout entry, no cycle boundary
    pd_req_n = 1'b0;
    repeat (6) step();
    chk("R5", "hold before timeout", clk_hold, 0);
    step();
    chk("R5", "hold at timeout", clk_hold, 1);
    step();
    chk("R6", "osc off after timeout", osc_en, 0);

    // R10 abort during settle
    pd_req_n = 1'b1;
    repeat (3) step();
    chk("R10", "in settle", osc_en, 1);
    ref_tick = 1'b1;
    repeat (3) step();
    ref_tick = 1'b0; pd_req_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10", "no pulse cpu", cpu_run, 0);
      chk("R10", "no pulse bus", bus_run, 0);
      chk("R10", "hold kept", clk_hold, 1);
    end
    chk("R10", "back to osc off", osc_en, 0);

    // wake again: full count needed
    pd_req_n = 1'b1;
    repeat (3) step();
    ref_tick = 1'b1;
    repeat (7) step();
    chk("R10", "count restarted", clk_hold, 1);
    step();
    chk("R9", "release after full count", clk_hold, 0);
    ref_tick = 1'b0;
    chk("R8", "retained", cfg_q, 8'hA5);
    chk("R6", "vco_en running", vco_en, 1);

    summary();
    $finish;
  end
endmodule